// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block buffers 9-bit words between two unrelated clock domains. A producer writes on its own clock and a consumer reads on another. Four active-low status flags tell each side how much room or data remains. Empty and almost-empty are produced on the read clock. Full and almost-full are produced on the write clock.

The write and read pointers are binary counters with one extra wrap bit. Each pointer is converted to Gray code and passed through a two-flop synchronizer into the other domain. Each side computes the word count from its own pointer and the synchronized copy of the other pointer. The two almost thresholds are run-time inputs, supplied by a separate offset-register block.

The level of the second write-enable pin during reset selects one of two modes:
- **Two-enable mode:** the pin acts as a second write enable, which suits depth expansion.
- **Load-control mode:** the pin acts as a load control. While it is low, the block raises a load strobe for the offset-register block and stores no data.

The read output register keeps the last word read.

Top module: `dcf_flag_fifo`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are: empty_no=0, aempty_no=0, full_no=1, afull_no=1, rdata_o=0.
- R2: wen2_ld_i is sampled on write-clock edges while reset is asserted, and on the first edge after release. If it was high, prog_mode_o=0 (two-enable mode). If it was low, prog_mode_o=1 (load-control mode). prog_mode_o then holds until the next reset, whatever the pin does.
- R3: A word is stored on a write-clock edge only when wen1_ni=0, wen2_ld_i=1 and full_no=1. In load-control mode, wen1_ni=0 with wen2_ld_i=0 drives ofs_ld_o=1 and stores no word. ofs_ld_o stays 0 in two-enable mode.
- R4: A read happens on a read-clock edge only when ren1_ni=0, ren2_ni=0 and empty_no=1. On that edge rdata_o takes the oldest stored word. With either enable high, rdata_o is unchanged.
- R5: Words leave in the order they were written, including when writes and reads run at the same time on unrelated clocks.
- R6: full_no is 0 exactly when DEPTH words are held. Writes attempted while full_no=0 are ignored.
- R7: empty_no is 0 exactly when no words are held. Reads attempted while empty_no=0 are ignored, and rdata_o keeps the last word read.
- R8: aempty_no is 0 when the count is at most aempty_thr_i (n), and 1 when the count is n+1 or more. It changes only on the read clock.
- R9: afull_no is 0 when the count is at least DEPTH−afull_thr_i (m), and 1 otherwise. It changes only on the write clock. The usual setting is n=m=7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset, released synchronously in each domain |
| wclk_i | input | 1 | Write clock |
| wen1_ni | input | 1 | Write enable, active low |
| wen2_ld_i | input | 1 | Second write enable (high) or offset load control (low) |
| wdata_i | input | DATA_W | Write data |
| rclk_i | input | 1 | Read clock |
| ren1_ni | input | 1 | First read enable, active low |
| ren2_ni | input | 1 | Second read enable, active low |
| aempty_thr_i | input | PW | Almost-empty threshold n |
| afull_thr_i | input | PW | Almost-full threshold m |
| rdata_o | output | DATA_W | Registered read data |
| empty_no | output | 1 | Empty flag, active low, read clock |
| aempty_no | output | 1 | Almost-empty flag, active low, read clock |
| full_no | output | 1 | Full flag, active low, write clock |
| afull_no | output | 1 | Almost-full flag, active low, write clock |
| prog_mode_o | output | 1 | Latched mode: 1 = load-control mode |
| ofs_ld_o | output | 1 | Offset load strobe for the offset-register block |

## Verification
The assertions check the following on every cycle:
- The pointers never advance while their own side's flag blocks them, and the data output holds while empty.
- The write count never goes past the depth.
- The Gray pointer moves by at most one bit per edge.
- Empty implies almost-empty, and full implies almost-full.
- The latched mode never moves outside reset.

Only the bench scenarios can show:
- The exact flag levels at the n, n+1, DEPTH−m and DEPTH boundaries once the pointers have crossed.
- The order of words under unrelated clocks.
- The threshold changes made at run time.
- The mode selection done by the pin level during reset.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  function automatic logic [31:0] bin2gray(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end
  assign rst_no = stg_q[1];
endmodule

// File: rtl/dcf_ptr_sync.sv
`timescale 1ns/1ps
module dcf_ptr_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DATA_W = 9,
  parameter int AW     = 5
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
`timescale 1ns/1ps
module dcf_wr_ctrl #(
  parameter int PW = 6
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_ld_i,
  input  logic [PW-1:0] rgray_sync_i,
  input  logic [PW-1:0] afull_thr_i,
  output logic          wr_en_o,
  output logic [PW-2:0] waddr_o,
  output logic [PW-1:0] wgray_o,
  output logic          full_no,
  output logic          afull_no,
  output logic          prog_mode_o,
  output logic          ofs_ld_o
);
  import dcf_pkg::*;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {(PW-1){1'b0}}};

  logic          in_rst_q, prog_q;
  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, rptr_bin, cnt_nxt;
  logic [PW:0]   fill_sum;
  logic          full_n_q, afull_n_q, wr_en;

  // high while reset is asserted and for one edge after release
  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) in_rst_q <= 1'b1;
    else          in_rst_q <= 1'b0;
  end

  always_ff @(posedge wclk_i) begin
    if (in_rst_q) prog_q <= ~wen2_ld_i;
  end

  assign wr_en    = ~in_rst_q & ~wen1_ni & wen2_ld_i & full_n_q;
  assign ofs_ld_o = ~in_rst_q & prog_q & ~wen1_ni & ~wen2_ld_i;
  assign rptr_bin = PW'(gray2bin(32'(rgray_sync_i)));
  assign wptr_nxt = wptr_q + {{(PW-1){1'b0}}, wr_en};
  assign cnt_nxt  = wptr_nxt - rptr_bin;
  assign fill_sum = {1'b0, cnt_nxt} + {1'b0, afull_thr_i};

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wptr_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      wptr_q    <= wptr_nxt;
      wgray_q   <= PW'(bin2gray(32'(wptr_nxt)));
      full_n_q  <= (cnt_nxt != FULL_CNT);
      afull_n_q <= (fill_sum < {1'b0, FULL_CNT});
    end
  end

  assign wr_en_o     = wr_en;
  assign waddr_o     = wptr_q[PW-2:0];
  assign wgray_o     = wgray_q;
  assign full_no     = full_n_q;
  assign afull_no    = afull_n_q;
  assign prog_mode_o = prog_q;

  assert_no_overflow_R6: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !full_n_q |=> (wptr_q == $past(wptr_q)));
  assert_count_bound_R6: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (PW'(wptr_q - rptr_bin) <= FULL_CNT));
  assert_full_in_afull_R9: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !full_n_q |-> !afull_n_q);
  assert_gray_step_R5: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    !in_rst_q |-> ($countones(wgray_q ^ $past(wgray_q)) <= 1));
  assert_mode_hold_R2: assert property (@(posedge wclk_i) disable iff (!wrst_ni)
    (!in_rst_q && !$past(in_rst_q)) |-> $stable(prog_q));
endmodule

// File: rtl/dcf_rd_ctrl.sv
`timescale 1ns/1ps
module dcf_rd_ctrl #(
  parameter int PW     = 6,
  parameter int DATA_W = 9
) (
  input  logic              rclk_i,
  input  logic              rrst_ni,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic [PW-1:0]     wgray_sync_i,
  input  logic [PW-1:0]     aempty_thr_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [PW-2:0]     raddr_o,
  output logic [PW-1:0]     rgray_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              aempty_no
);
  import dcf_pkg::*;

  logic [PW-1:0]     rptr_q, rptr_nxt, rgray_q, wptr_bin, cnt_nxt;
  logic [DATA_W-1:0] dout_q;
  logic              empty_n_q, aempty_n_q, rd_en;

  assign rd_en    = ~ren1_ni & ~ren2_ni & empty_n_q;
  assign wptr_bin = PW'(gray2bin(32'(wgray_sync_i)));
  assign rptr_nxt = rptr_q + {{(PW-1){1'b0}}, rd_en};
  assign cnt_nxt  = wptr_bin - rptr_nxt;

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      rptr_q     <= '0;
      rgray_q    <= '0;
      dout_q     <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rptr_q     <= rptr_nxt;
      rgray_q    <= PW'(bin2gray(32'(rptr_nxt)));
      empty_n_q  <= (cnt_nxt != '0);
      aempty_n_q <= (cnt_nxt > aempty_thr_i);
      if (rd_en) dout_q <= ram_rdata_i;
    end
  end

  assign raddr_o   = rptr_q[PW-2:0];
  assign rgray_o   = rgray_q;
  assign rdata_o   = dout_q;
  assign empty_no  = empty_n_q;
  assign aempty_no = aempty_n_q;

  assert_no_underflow_R7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !empty_n_q |=> ((rptr_q == $past(rptr_q)) && (dout_q == $past(dout_q))));
  assert_empty_in_aempty_R8: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !empty_n_q |-> !aempty_n_q);
  assert_idle_hold_R4: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (ren1_ni || ren2_ni) |=> $stable(dout_q));
  assert_rgray_step_R5: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dcf_flag_fifo.sv
`timescale 1ns/1ps
module dcf_flag_fifo #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 32,
  parameter int AW     = $clog2(DEPTH),
  parameter int PW     = AW + 1
) (
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              wen1_ni,
  input  logic              wen2_ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rclk_i,
  input  logic              ren1_ni,
  input  logic              ren2_ni,
  input  logic [PW-1:0]     aempty_thr_i,
  input  logic [PW-1:0]     afull_thr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_no,
  output logic              aempty_no,
  output logic              full_no,
  output logic              afull_no,
  output logic              prog_mode_o,
  output logic              ofs_ld_o
);
  logic              wrst_n, rrst_n, wr_en;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  logic [DATA_W-1:0] ram_rdata;

  dcf_rst_sync u_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(wrst_n));
  dcf_rst_sync u_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rrst_n));

  dcf_ptr_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni(rrst_n), .d_i(wgray), .q_o(wgray_rs));
  dcf_ptr_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni(wrst_n), .d_i(rgray), .q_o(rgray_ws));

  dcf_ram #(.DATA_W(DATA_W), .AW(AW)) u_ram (
    .wclk_i(wclk_i), .we_i(wr_en), .waddr_i(waddr), .wdata_i(wdata_i),
    .raddr_i(raddr), .rdata_o(ram_rdata));

  dcf_wr_ctrl #(.PW(PW)) u_wr (
    .wclk_i(wclk_i), .wrst_ni(wrst_n), .wen1_ni(wen1_ni), .wen2_ld_i(wen2_ld_i),
    .rgray_sync_i(rgray_ws), .afull_thr_i(afull_thr_i), .wr_en_o(wr_en),
    .waddr_o(waddr), .wgray_o(wgray), .full_no(full_no), .afull_no(afull_no),
    .prog_mode_o(prog_mode_o), .ofs_ld_o(ofs_ld_o));

  dcf_rd_ctrl #(.PW(PW), .DATA_W(DATA_W)) u_rd (
    .rclk_i(rclk_i), .rrst_ni(rrst_n), .ren1_ni(ren1_ni), .ren2_ni(ren2_ni),
    .wgray_sync_i(wgray_rs), .aempty_thr_i(aempty_thr_i), .ram_rdata_i(ram_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .rdata_o(rdata_o),
    .empty_no(empty_no), .aempty_no(aempty_no));
endmodule

// File: tb/dcf_flag_fifo_test.sv
`timescale 1ns/1ps
module dcf_flag_fifo_test;
  localparam int DW = 9;
  localparam int DEPTH = 16;
  localparam int PW = 5;

  logic rst_ni = 1'b0, wclk = 1'b0, rclk = 1'b0;
  logic wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [PW-1:0] n_thr = 5'd7, m_thr = 5'd7;
  logic [DW-1:0] rdata;
  logic empty_n, aempty_n, full_n, afull_n, prog_mode, ofs_ld;

  int checks = 0, fails = 0, rx = 0;
  bit done = 0;
  logic [DW-1:0] sb[$];
  logic [DW-1:0] last_rd = '0;

  always #5 wclk = ~wclk;
  always #7 rclk = ~rclk;

  dcf_flag_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .rst_ni(rst_ni), .wclk_i(wclk), .wen1_ni(wen1_n), .wen2_ld_i(wen2_ld), .wdata_i(wdata),
    .rclk_i(rclk), .ren1_ni(ren1_n), .ren2_ni(ren2_n), .aempty_thr_i(n_thr),
    .afull_thr_i(m_thr), .rdata_o(rdata), .empty_no(empty_n), .aempty_no(aempty_n),
    .full_no(full_n), .afull_no(afull_n), .prog_mode_o(prog_mode), .ofs_ld_o(ofs_ld));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic pin);
    rst_ni = 1'b0; wen1_n = 1'b1; wen2_ld = pin; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (4) @(negedge wclk);
    rst_ni = 1'b1;
    repeat (3) @(negedge wclk);
    repeat (4) @(negedge rclk);
    sb.delete();
    last_rd = '0;
  endtask

  task automatic wr(input logic [DW-1:0] d, input logic en2, output bit acc);
    @(negedge wclk);
    wdata = d; wen1_n = 1'b0; wen2_ld = en2;
    acc = en2 && full_n;
    if (acc) sb.push_back(d);
  endtask

  task automatic wr_idle();
    @(negedge wclk);
    wen1_n = 1'b1; wen2_ld = 1'b1;
  endtask

  task automatic wr_n(input int cnt, input logic [DW-1:0] base);
    for (int i = 0; i < cnt; i++) begin
      bit a;
      wr(base + DW'(i), 1'b1, a);
    end
    wr_idle();
  endtask

  task automatic rd(input logic r1, input logic r2, input string req);
    bit acc;
    logic [DW-1:0] exp;
    @(negedge rclk);
    ren1_n = r1; ren2_n = r2;
    acc = !r1 && !r2 && empty_n;
    @(negedge rclk);
    ren1_n = 1'b1; ren2_n = 1'b1;
    if (acc) begin
      exp = sb.pop_front();
      check(req, 32'(rdata), 32'(exp));
      last_rd = exp;
      rx++;
    end else begin
      check(req, 32'(rdata), 32'(last_rd));
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge wclk);
    repeat (6) @(negedge rclk);
  endtask

  task automatic flag_chk(input string ctx);
    int c;
    c = sb.size();
    check({"R7 empty ", ctx}, 32'(empty_n), 32'(c != 0));
    check({"R8 aempty ", ctx}, 32'(aempty_n), 32'(c > int'(n_thr)));
    check({"R6 full ", ctx}, 32'(full_n), 32'(c != DEPTH));
    check({"R9 afull ", ctx}, 32'(afull_n), 32'(c < DEPTH - int'(m_thr)));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    // R1 reset state, two-enable mode
    rst_ni = 1'b0; wen2_ld = 1'b1;
    repeat (2) @(negedge wclk);
    check("R1 empty in reset", 32'(empty_n), 0);
    check("R1 full in reset", 32'(full_n), 1);
    do_reset(1'b1);
    check("R1 rdata", 32'(rdata), 0);
    check("R1 empty", 32'(empty_n), 0);
    check("R1 aempty", 32'(aempty_n), 0);
    check("R1 full", 32'(full_n), 1);
    check("R1 afull", 32'(afull_n), 1);
    check("R2 two-enable mode", 32'(prog_mode), 0);
    @(negedge wclk); wen2_ld = 1'b0; #1;
    check("R2 mode held", 32'(prog_mode), 0);
    check("R3 no load strobe", 32'(ofs_ld), 0);
    wr_idle();

    // fill through the thresholds, n=m=7
    wr_n(5, 9'h010);
    wr(9'h1AA, 1'b0, a); #1;
    check("R3 no strobe in two-enable mode", 32'(ofs_ld), 0);
    wr_idle(); settle(); flag_chk("at 5");
    wr_n(3, 9'h020); settle(); flag_chk("at 8 (n+1)");
    wr_n(1, 9'h030); settle(); flag_chk("at 9 (DEPTH-m)");
    wr_n(7, 9'h040); settle(); flag_chk("at 16 full");
    wr_n(3, 9'h1F0); settle(); flag_chk("writes while full");
    rd(1'b0, 1'b1, "R4 ren2 high");
    rd(1'b1, 1'b0, "R4 ren1 high");
    for (int i = 0; i < 16; i++) rd(1'b0, 1'b0, "R5 drain order");
    for (int i = 0; i < 3; i++) rd(1'b0, 1'b0, "R7 hold on empty");
    settle(); flag_chk("drained");

    // concurrent traffic on unrelated clocks
    rx = 0;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          bit acc;
          if (i % 5 == 4) wr(9'h0FF, 1'b0, acc);
          acc = 0;
          while (!acc) wr(DW'(i * 7 + 3), 1'b1, acc);
        end
        wr_idle();
      end
      begin
        for (int k = 0; rx < 40; k++) rd((k % 3) == 2, 1'b0, "R5 concurrent order");
      end
    join
    settle(); flag_chk("after concurrent");

    // run-time thresholds n=2, m=4
    n_thr = 5'd2; m_thr = 5'd4;
    wr_n(2, 9'h100); settle(); flag_chk("n=2 at 2");
    wr_n(1, 9'h110); settle(); flag_chk("n=2 at 3");
    wr_n(8, 9'h120); settle(); flag_chk("m=4 at 11");
    wr_n(1, 9'h130); settle(); flag_chk("m=4 at 12");
    for (int i = 0; i < 12; i++) rd(1'b0, 1'b0, "R5 drain thresholds");
    settle(); flag_chk("drained again");

    // load-control mode
    n_thr = 5'd7; m_thr = 5'd7;
    do_reset(1'b0);
    check("R2 load-control mode", 32'(prog_mode), 1);
    check("R1 rdata after reset", 32'(rdata), 0);
    @(negedge wclk); wen2_ld = 1'b1; #1;
    check("R2 mode held high pin", 32'(prog_mode), 1);
    wr(9'h055, 1'b0, a); #1;
    check("R3 load strobe", 32'(ofs_ld), 1);
    wr_idle(); #1;
    check("R3 strobe idle", 32'(ofs_ld), 0);
    settle(); flag_chk("R3 load stored nothing");
    wr_n(1, 9'h066); settle(); flag_chk("one word load-control mode");
    rd(1'b0, 1'b0, "R3 single-enable write");
    settle(); flag_chk("end");

    done = 1;
    summary();
    $finish;
  end
endmodule